// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a 32-bit processor whose instructions are all one word long and word aligned. It also works out the address to fetch next. Instructions arrive on a valid/ready channel. When one is accepted, the counter moves to the address that instruction selects. For most instructions that is the following word. Two conditional branches compare two source registers for equality and, when taken, add a scaled signed offset. A direct jump replaces the low bits of the address with an index. A register jump loads a register value. A linking jump also sends a return address toward the register file.

The link write leaves the block on its own valid/ready channel. A linking jump is only accepted in the cycle where that channel can take its write. When `link_ready` is low, the unit holds the linking jump on the instruction channel by keeping `inst_ready` low. Any other instruction is accepted whenever it is valid. `next_pc` is combinational and always shows the target of the instruction currently on the inputs.

Top module: `nextpc_unit`

## Requirements
- R1: While reset is active, and in the first cycle after it, `pc` equals the RESET_VEC parameter.
- R2: An accepted instruction that is not a control transfer sets `pc` to its previous value plus 4. This includes every instruction with opcode 0 (bits 31:26) whose function field (bits 5:0) is not 6'h08.
- R3: An accepted equal-branch (opcode 6'h04) with `rs_eq_rt` high sets `pc` to old `pc` + 4 + (sign-extended bits 15:0 shifted left by 2). With `rs_eq_rt` low it sets `pc` to old `pc` + 4.
- R4: An accepted not-equal-branch (opcode 6'h05) takes the branch target of R3 when `rs_eq_rt` is low. It goes to old `pc` + 4 when `rs_eq_rt` is high.
- R5: Branch offsets are signed: a 16-bit immediate with bit 15 set moves `pc` backwards. 16'h8000 gives an offset of -131072 bytes.
- R6: An accepted direct jump (opcode 6'h02) sets `pc` to {bits 31:28 of old `pc` + 4, instruction bits 25:0, 2'b00}.
- R7: An accepted register jump (opcode 0, function 6'h08) sets `pc` to `rs_value` exactly.
- R8: A linking jump (opcode 6'h03) drives `link_valid` high with `link_reg` = LINK_IDX (31) and `link_addr` = `pc` + 4. When accepted, it sets `pc` to the R6 target.
- R9: While a valid linking jump is present and `link_ready` is low, `inst_ready` is low and `pc` does not change. Instructions of other kinds are accepted whatever `link_ready` is.
- R10: In a cycle without a handshake on the instruction channel, `pc` keeps its value.
- R11: The upper four bits of a jump target come from `pc` + 4. A jump placed in the last word of a 256 MiB region therefore lands in the next region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inst_valid | input | 1 | Instruction word is present |
| inst_ready | output | 1 | Unit accepts the presented instruction |
| inst_word | input | 32 | Decoded instruction word |
| rs_value | input | 32 | Contents of source register rs |
| rs_eq_rt | input | 1 | High when rs and rt hold equal values |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Target selected by the presented instruction |
| link_valid | output | 1 | Return-address write is requested |
| link_ready | input | 1 | Register file accepts the write |
| link_reg | output | 5 | Destination register index of the write |
| link_addr | output | 32 | Return address to be written |

## Verification
The bench builds the unit with RESET_VEC = 32'h0FFF_FFF0, four words below a 256 MiB boundary. A few sequential steps then bring the counter to the last word of that region, where a direct jump has to take its upper bits from the carried `pc` + 4 (R11). LINK_IDX stays at 31. Register jumps relocate the counter to arbitrary addresses so that branches with large negative offsets can be exercised. The linking jump is presented with `link_ready` both low and high.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  localparam int ADDR_W   = 32;
  localparam int OPC_W    = 6;
  localparam int FUNC_W   = 6;
  localparam int IMM_W    = 16;
  localparam int INDEX_W  = 26;
  localparam int REGIDX_W = 5;
  localparam int WORD_SHIFT = 2;
  localparam int REGION_W = ADDR_W - INDEX_W - WORD_SHIFT;

  localparam logic [OPC_W-1:0]  OPC_SPECIAL = 6'h00;
  localparam logic [OPC_W-1:0]  OPC_JUMP    = 6'h02;
  localparam logic [OPC_W-1:0]  OPC_JLINK   = 6'h03;
  localparam logic [OPC_W-1:0]  OPC_BR_EQ   = 6'h04;
  localparam logic [OPC_W-1:0]  OPC_BR_NE   = 6'h05;
  localparam logic [FUNC_W-1:0] FN_JREG     = 6'h08;

  typedef enum logic [1:0] {
    FLOW_SEQ,
    FLOW_BRANCH,
    FLOW_JUMP,
    FLOW_JREG
  } flow_e;

  typedef struct packed {
    flow_e flow;
    logic  cond_ne;
    logic  link;
  } flow_ctl_t;
endpackage

// File: rtl/nextpc_decode.sv
module nextpc_decode
  import nextpc_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FUNC_W-1:0] funct,
  output flow_ctl_t         ctl
);
  always_comb begin
    ctl = '{flow: FLOW_SEQ, cond_ne: 1'b0, link: 1'b0};
    unique case (opcode)
      OPC_BR_EQ: ctl.flow = FLOW_BRANCH;
      OPC_BR_NE: begin
        ctl.flow    = FLOW_BRANCH;
        ctl.cond_ne = 1'b1;
      end
      OPC_JUMP:  ctl.flow = FLOW_JUMP;
      OPC_JLINK: begin
        ctl.flow = FLOW_JUMP;
        ctl.link = 1'b1;
      end
      OPC_SPECIAL: begin
        if (funct == FN_JREG) ctl.flow = FLOW_JREG;
      end
      default: ctl.flow = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/nextpc_targets.sv
module nextpc_targets
  import nextpc_pkg::*;
(
  input  logic [ADDR_W-1:0]  pc,
  input  logic [INDEX_W-1:0] index,
  output logic [ADDR_W-1:0]  pc_plus,
  output logic [ADDR_W-1:0]  br_target,
  output logic [ADDR_W-1:0]  jmp_target
);
  localparam int EXT_W = ADDR_W - IMM_W - WORD_SHIFT;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << WORD_SHIFT);

  logic [IMM_W-1:0]  imm;
  logic [ADDR_W-1:0] br_offset;

  assign imm       = index[IMM_W-1:0];
  assign pc_plus   = pc + STEP;
  assign br_offset = {{EXT_W{imm[IMM_W-1]}}, imm, {WORD_SHIFT{1'b0}}};
  assign br_target = pc_plus + br_offset;
  assign jmp_target = {pc_plus[ADDR_W-1 -: REGION_W], index, {WORD_SHIFT{1'b0}}};
endmodule

// File: rtl/nextpc_select.sv
module nextpc_select
  import nextpc_pkg::*;
(
  input  flow_ctl_t         ctl,
  input  logic              rs_eq_rt,
  input  logic [ADDR_W-1:0] pc_plus,
  input  logic [ADDR_W-1:0] br_target,
  input  logic [ADDR_W-1:0] jmp_target,
  input  logic [ADDR_W-1:0] rs_value,
  output logic [ADDR_W-1:0] next_pc
);
  logic taken;

  assign taken = ctl.cond_ne ? !rs_eq_rt : rs_eq_rt;

  always_comb begin
    unique case (ctl.flow)
      FLOW_BRANCH: next_pc = taken ? br_target : pc_plus;
      FLOW_JUMP:   next_pc = jmp_target;
      FLOW_JREG:   next_pc = rs_value;
      default:     next_pc = pc_plus;
    endcase
  end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0000_0000,
  parameter int          LINK_IDX  = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inst_valid,
  output logic        inst_ready,
  input  logic [31:0] inst_word,
  input  logic [31:0] rs_value,
  input  logic        rs_eq_rt,
  output logic [31:0] pc,
  output logic [31:0] next_pc,
  output logic        link_valid,
  input  logic        link_ready,
  output logic [4:0]  link_reg,
  output logic [31:0] link_addr
);
  localparam int OPC_LSB = ADDR_W - OPC_W;

  flow_ctl_t         ctl;
  logic [ADDR_W-1:0] pc_plus;
  logic [ADDR_W-1:0] br_target;
  logic [ADDR_W-1:0] jmp_target;
  logic [ADDR_W-1:0] pc_q;
  logic              accept;

  nextpc_decode u_decode (
    .opcode (inst_word[ADDR_W-1:OPC_LSB]),
    .funct  (inst_word[FUNC_W-1:0]),
    .ctl    (ctl)
  );

  nextpc_targets u_targets (
    .pc         (pc_q),
    .index      (inst_word[INDEX_W-1:0]),
    .pc_plus    (pc_plus),
    .br_target  (br_target),
    .jmp_target (jmp_target)
  );

  nextpc_select u_select (
    .ctl        (ctl),
    .rs_eq_rt   (rs_eq_rt),
    .pc_plus    (pc_plus),
    .br_target  (br_target),
    .jmp_target (jmp_target),
    .rs_value   (rs_value),
    .next_pc    (next_pc)
  );

  // a linking jump waits until its return-address write can be taken
  assign inst_ready = !ctl.link || link_ready;
  assign accept     = inst_valid && inst_ready;
  assign link_valid = inst_valid && ctl.link;
  assign link_reg   = REGIDX_W'(LINK_IDX);
  assign link_addr  = pc_plus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= RESET_VEC;
    else if (accept) pc_q <= next_pc;
  end

  assign pc = pc_q;
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk #(
  parameter logic [31:0] RESET_VEC = 32'h0000_0000,
  parameter int          LINK_IDX  = 31
) (
  input logic        clk,
  input logic        rst_n,
  input logic        inst_valid,
  input logic        inst_ready,
  input logic [5:0]  opcode,
  input logic [5:0]  funct,
  input logic [31:0] rs_value,
  input logic [31:0] pc,
  input logic [31:0] next_pc,
  input logic        link_valid,
  input logic        link_ready,
  input logic [4:0]  link_reg,
  input logic [31:0] link_addr
);
  logic fire, is_jreg, is_ctl;
  assign fire    = inst_valid && inst_ready;
  assign is_jreg = (opcode == 6'h00) && (funct == 6'h08);
  assign is_ctl  = (opcode == 6'h02) || (opcode == 6'h03) || (opcode == 6'h04) ||
                   (opcode == 6'h05) || is_jreg;

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> pc == RESET_VEC);

  assert_sequential_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !is_ctl |=> pc == $past(pc) + 32'd4);

  assert_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pc == $past(next_pc));

  assert_jreg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && is_jreg |=> pc == $past(rs_value));

  assert_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |-> (link_addr == pc + 32'd4) && (link_reg == 5'(LINK_IDX)));

  assert_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inst_valid && (opcode == 6'h03) && !link_ready |-> !inst_ready);

  assert_other_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    opcode != 6'h03 |-> inst_ready);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(pc));
endmodule

bind nextpc_unit nextpc_unit_chk #(.RESET_VEC(RESET_VEC), .LINK_IDX(LINK_IDX)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .inst_valid (inst_valid),
  .inst_ready (inst_ready),
  .opcode     (inst_word[31:26]),
  .funct      (inst_word[5:0]),
  .rs_value   (rs_value),
  .pc         (pc),
  .next_pc    (next_pc),
  .link_valid (link_valid),
  .link_ready (link_ready),
  .link_reg   (link_reg),
  .link_addr  (link_addr)
);

// File: tb/test_nextpc_unit.sv
`timescale 1ns/1ps
module test_nextpc_unit;
  localparam logic [31:0] RVEC = 32'h0FFF_FFF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inst_valid = 1'b0;
  logic        inst_ready;
  logic [31:0] inst_word = '0;
  logic [31:0] rs_value = '0;
  logic        rs_eq_rt = 1'b0;
  logic [31:0] pc;
  logic [31:0] next_pc;
  logic        link_valid;
  logic        link_ready = 1'b1;
  logic [4:0]  link_reg;
  logic [31:0] link_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nextpc_unit #(.RESET_VEC(RVEC), .LINK_IDX(31)) i_nextpc_unit (
    .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst_ready(inst_ready),
    .inst_word(inst_word), .rs_value(rs_value), .rs_eq_rt(rs_eq_rt),
    .pc(pc), .next_pc(next_pc), .link_valid(link_valid), .link_ready(link_ready),
    .link_reg(link_reg), .link_addr(link_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_imm(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd8, 5'd9, imm};
  endfunction
  function automatic logic [31:0] enc_jmp(input logic [5:0] op, input logic [25:0] idx);
    return {op, idx};
  endfunction
  function automatic logic [31:0] br_tgt(input logic [31:0] p, input logic [15:0] imm);
    return p + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
  endfunction
  function automatic logic [31:0] j_tgt(input logic [31:0] p, input logic [25:0] idx);
    logic [31:0] p4;
    p4 = p + 32'd4;
    return {p4[31:28], idx, 2'b00};
  endfunction

  // present one instruction for one clock, then check pc
  task automatic step(input string req, input logic [31:0] iw, input logic [31:0] rsv,
                      input logic eq, input logic [31:0] exp_pc);
    @(negedge clk);
    inst_word  = iw;
    rs_value   = rsv;
    rs_eq_rt   = eq;
    inst_valid = 1'b1;
    @(negedge clk);
    inst_valid = 1'b0;
    check(req, pc, exp_pc);
  endtask

  task automatic t_reset();
    check("R1 reset value", pc, RVEC);
    @(negedge clk); rst_n = 1'b1;
    check("R1 after release", pc, RVEC);
  endtask

  task automatic t_sequential();
    logic [31:0] p;
    p = pc;
    step("R2 register op", 32'h012A_4020, 32'h0, 1'b0, p + 32'd4);
    p = pc;
    step("R2 immediate op", enc_imm(6'h0D, 16'hFFFF), 32'h0, 1'b1, p + 32'd4);
    p = pc;
    step("R3 equal not taken", enc_imm(6'h04, 16'h0010), 32'h0, 1'b0, p + 32'd4);
  endtask

  task automatic t_region_jump();
    logic [31:0] p;
    p = pc;
    check("R11 setup at region end", p, 32'h0FFF_FFFC);
    step("R11 jump region from pc+4", enc_jmp(6'h02, 26'h000_0010), 32'h0, 1'b0, 32'h1000_0040);
  endtask

  task automatic t_hold();
    logic [31:0] p;
    p = pc;
    @(negedge clk);
    inst_word = enc_jmp(6'h02, 26'h3FF_FFFF);
    rs_eq_rt  = 1'b1;
    @(negedge clk);
    check("R10 idle hold", pc, p);
  endtask

  task automatic t_branches();
    logic [31:0] p;
    p = pc;
    step("R3 equal taken", enc_imm(6'h04, 16'h0003), 32'h0, 1'b1, br_tgt(p, 16'h0003));
    p = pc;
    step("R4 not-equal taken backward", enc_imm(6'h05, 16'hFFFE), 32'h0, 1'b0, br_tgt(p, 16'hFFFE));
    check("R5 backward value", pc, 32'h1000_004C);
    p = pc;
    step("R4 not-equal not taken", enc_imm(6'h05, 16'h0040), 32'h0, 1'b1, p + 32'd4);
    p = pc;
    step("R5 most negative offset", enc_imm(6'h04, 16'h8000), 32'h0, 1'b1, p + 32'd4 - 32'd131072);
  endtask

  task automatic t_jreg();
    step("R7 register jump", 32'h0100_0008, 32'h2000_0100, 1'b0, 32'h2000_0100);
    step("R7 register jump odd", 32'h03E0_0008, 32'hDEAD_BEE4, 1'b1, 32'hDEAD_BEE4);
    step("R6 direct jump", enc_jmp(6'h02, 26'h123_4567), 32'h0, 1'b0, j_tgt(32'hDEAD_BEE4, 26'h123_4567));
  endtask

  task automatic t_link();
    logic [31:0] p;
    p = pc;
    @(negedge clk);
    link_ready = 1'b0;
    inst_word  = enc_jmp(6'h03, 26'h000_0100);
    inst_valid = 1'b1;
    #1;
    check("R9 ready low under back-pressure", {31'd0, inst_ready}, 32'd0);
    check("R8 link valid", {31'd0, link_valid}, 32'd1);
    @(negedge clk);
    check("R9 pc held while stalled", pc, p);
    link_ready = 1'b1;
    #1;
    check("R8 link address", link_addr, p + 32'd4);
    check("R8 link register", {27'd0, link_reg}, 32'd31);
    check("R9 ready once link accepted", {31'd0, inst_ready}, 32'd1);
    @(negedge clk);
    inst_valid = 1'b0;
    check("R8 linking jump target", pc, j_tgt(p, 26'h000_0100));
    @(negedge clk);
    link_ready = 1'b0;
    p = pc;
    step("R9 other op under low link_ready", 32'h012A_4020, 32'h0, 1'b0, p + 32'd4);
    link_ready = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sequential();
    t_region_jump();
    t_hold();
    t_branches();
    t_jreg();
    t_link();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule